// File: doc/BRIEF.md
# Sleep Mode and Wake-up Controller

This block sequences the low-power states of a small microcontroller. When software raises a sleep request, the block decodes a three-bit depth code. It latches the chosen depth and then drives separate enables for the main oscillator, the core and I/O clock domain, and the two clock inputs of the second timer (its asynchronous oscillator and its synchronous feed). The block itself runs on an always-on clock.

While asleep it watches the wake sources the chosen depth allows. A reset-class source (external, watchdog or brown-out) drops the block straight back to the awake state without a wake pulse. A level-type interrupt must hold for a qualification window before it counts. Any other qualified source starts a restart wait, which is either a fixed six cycles (the two standby depths, oscillator still on) or the programmable start-up value (the two deep depths, oscillator off). When the wait ends, the core clock returns and a one-cycle wake pulse is issued.

Codes other than 010, 011, 110 and 111 are refused, and so are 110 and 111 without the crystal option. A refused request leaves the block awake and raises an error flag.

Top module: `slpctl_top`

## Requirements
- R1: After reset the block is awake: osc_en_o, core_clk_en_o, t2_async_en_o and t2_sync_en_o are 1, and sleeping_o, wake_pulse_o and mode_err_o are 0.
- R2: A sleep request while awake is accepted for code 010 or 011, and for 110 or 111 only when xtal_opt_i is 1. An accepted request sets sleeping_o from the next cycle. Any other request leaves sleeping_o at 0 and sets mode_err_o from the next cycle. mode_err_o is rewritten by each later request made while awake: 1 if refused for its code, 0 otherwise.
- R3: While asleep, core_clk_en_o is 0. osc_en_o is 1 only for codes 110 and 111, or when the timer's synchronous feed is kept (R4).
- R4: While asleep under code 011 or 111 with t2_en_i set, t2_async_en_o follows t2_async_i and t2_sync_en_o follows t2_sync_i. Under any other code, or with t2_en_i clear, both are 0.
- R5: A timer overflow (t2_ovf_i) or compare event (t2_cmp_i) wakes the block only under code 011 or 111, and only with t2_en_i, gie_i and that event's enable bit all set.
- R6: Under every accepted code, a one-cycle pulse on twi_match_i, ext_edge_i or pin_chg_i wakes the block.
- R7: ext_level_i counts as a wake only after it has been 1 for LVL_HOLD consecutive asleep cycles (default 3). A shorter high run has no effect.
- R8: The wake pulse appears N cycles after the clock edge that samples the qualified source. N is 6 under codes 110 and 111. Under 010 and 011, N is startup_dly_i, with 0 treated as 1.
- R9: wake_pulse_o lasts exactly one cycle. In that cycle sleeping_o is 0 and core_clk_en_o is 1.
- R10: rst_ext_i, rst_wdt_i or rst_bod_i, seen while asleep or during the restart wait, returns the block to awake on the next edge with no wake pulse, then or later.
- R11: A sleep request in the same cycle as any raw wake source leaves the block awake, with mode_err_o 0 for a valid code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-on clock |
| rst_n | input | 1 | active-low asynchronous reset |
| mode_i | input | 3 | sleep depth code |
| sleep_req_i | input | 1 | sleep request, one cycle |
| xtal_opt_i | input | 1 | external crystal clock option chosen |
| gie_i | input | 1 | global interrupt enable |
| t2_en_i | input | 1 | timer 2 running |
| t2_async_i | input | 1 | timer 2 uses its asynchronous oscillator |
| t2_sync_i | input | 1 | timer 2 uses the synchronous clock |
| t2_ovf_ie_i | input | 1 | timer 2 overflow interrupt enable |
| t2_cmp_ie_i | input | 1 | timer 2 compare interrupt enable |
| t2_ovf_i | input | 1 | timer 2 overflow event |
| t2_cmp_i | input | 1 | timer 2 compare event |
| rst_ext_i | input | 1 | external reset source |
| rst_wdt_i | input | 1 | watchdog reset source |
| rst_bod_i | input | 1 | brown-out reset source |
| twi_match_i | input | 1 | two-wire address match |
| ext_level_i | input | 1 | level-type external interrupt |
| ext_edge_i | input | 1 | edge-type external interrupt |
| pin_chg_i | input | 1 | pin-change interrupt |
| startup_dly_i | input | DLYW | restart wait for the deep depths, in cycles |
| osc_en_o | output | 1 | main oscillator enable |
| core_clk_en_o | output | 1 | core and I/O clock enable |
| t2_async_en_o | output | 1 | timer 2 asynchronous oscillator enable |
| t2_sync_en_o | output | 1 | timer 2 synchronous clock enable |
| sleeping_o | output | 1 | asleep or in the restart wait |
| wake_pulse_o | output | 1 | one-cycle pulse when a wake completes |
| mode_err_o | output | 1 | last request refused for its code |

## Verification
Two pairs of events can fall in the same cycle. The first is a sleep request and a wake source: the bench raises a pin change or a level input together with the request, and expects the block to stay awake with no error. The second is a reset-class source and the last cycle of the restart wait. With a start-up value of five, the bench raises the brown-out input exactly in the cycle where the wake pulse would be registered. It expects the block awake on the next sample, with no pulse then or in the cycles after.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ASLEEP = 2'd1,
    ST_WAKING = 2'd2
  } slp_state_e;

  typedef struct packed {
    logic valid;
    logic keep_osc;
    logic keep_t2;
  } slp_mode_t;

  // bit 2 of the code: oscillator kept; bit 0: timer 2 may be kept
  function automatic slp_mode_t decode_mode(logic [2:0] code, logic xtal);
    slp_mode_t r;
    r.keep_osc = code[2];
    r.keep_t2  = code[0];
    r.valid    = (code[1] == 1'b1) && ((code[2] == 1'b0) || xtal);
    return r;
  endfunction

  function automatic int unsigned wake_latency(logic keep_osc, int unsigned dly,
                                               int unsigned fixed_wait);
    if (keep_osc) return fixed_wait;
    return (dly == 0) ? 1 : dly;
  endfunction

  function automatic logic t2_event_ok(logic keep_t2, logic en, logic gie,
                                       logic ovf, logic ovf_ie,
                                       logic cmp, logic cmp_ie);
    return keep_t2 & en & gie & ((ovf & ovf_ie) | (cmp & cmp_ie));
  endfunction

endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual #(
  parameter int LVL_HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asleep_i,
  input  logic sleep_keep_t2_i,
  input  logic req_keep_t2_i,
  input  logic gie_i,
  input  logic t2_en_i,
  input  logic t2_ovf_ie_i,
  input  logic t2_cmp_ie_i,
  input  logic t2_ovf_i,
  input  logic t2_cmp_i,
  input  logic twi_match_i,
  input  logic ext_level_i,
  input  logic ext_edge_i,
  input  logic pin_chg_i,
  input  logic rst_ext_i,
  input  logic rst_wdt_i,
  input  logic rst_bod_i,
  output logic rst_wake_o,
  output logic soft_wake_o,
  output logic entry_block_o
);
  localparam int QW = (LVL_HOLD > 1) ? $clog2(LVL_HOLD) : 1;
  localparam logic [QW-1:0] SAT = QW'(LVL_HOLD - 1);

  logic [QW-1:0] run_q;
  logic          lvl_ok;
  logic          tmr_sleep_ok;
  logic          tmr_req_ok;
  logic          pulse_src;

  // count consecutive high asleep cycles of the level input, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       run_q <= '0;
    else if (!(asleep_i && ext_level_i)) run_q <= '0;
    else if (run_q < SAT)             run_q <= run_q + 1'b1;
  end

  assign lvl_ok = asleep_i & ext_level_i & (run_q >= SAT);

  assign tmr_sleep_ok = slp_pkg::t2_event_ok(sleep_keep_t2_i, t2_en_i, gie_i,
                          t2_ovf_i, t2_ovf_ie_i, t2_cmp_i, t2_cmp_ie_i);
  assign tmr_req_ok   = slp_pkg::t2_event_ok(req_keep_t2_i, t2_en_i, gie_i,
                          t2_ovf_i, t2_ovf_ie_i, t2_cmp_i, t2_cmp_ie_i);

  assign pulse_src     = twi_match_i | ext_edge_i | pin_chg_i;
  assign rst_wake_o    = rst_ext_i | rst_wdt_i | rst_bod_i;
  assign soft_wake_o   = asleep_i & (pulse_src | lvl_ok | tmr_sleep_ok);
  assign entry_block_o = rst_wake_o | pulse_src | ext_level_i | tmr_req_ok;

  // R7
  lvl_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LVL_HOLD > 1 && lvl_ok) |-> $past(asleep_i && ext_level_i));

endmodule

// File: rtl/slp_seq.sv
module slp_seq #(
  parameter int DLYW       = 8,
  parameter int FIXED_WAKE = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req_i,
  input  slp_pkg::slp_mode_t  req_mode_i,
  input  logic [DLYW-1:0]     startup_dly_i,
  input  logic                rst_wake_i,
  input  logic                soft_wake_i,
  input  logic                entry_block_i,
  output slp_pkg::slp_state_e state_o,
  output logic                keep_osc_o,
  output logic                keep_t2_o,
  output logic                wake_pulse_o,
  output logic                mode_err_o
);
  import slp_pkg::*;

  localparam int CNTW = (DLYW > 3) ? DLYW : 3;

  slp_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            osc_q, osc_d, t2_q, t2_d;
  logic            pulse_q, pulse_d;
  logic            err_q, err_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    osc_d   = osc_q;
    t2_d    = t2_q;
    pulse_d = 1'b0;
    err_d   = err_q;
    case (state_q)
      ST_AWAKE: begin
        if (sleep_req_i) begin
          err_d = !req_mode_i.valid;
          if (req_mode_i.valid && !entry_block_i) begin
            state_d = ST_ASLEEP;
            osc_d   = req_mode_i.keep_osc;
            t2_d    = req_mode_i.keep_t2;
          end
        end
      end
      ST_ASLEEP: begin
        if (rst_wake_i) state_d = ST_AWAKE;
        else if (soft_wake_i) begin
          state_d = ST_WAKING;
          cnt_d   = CNTW'(wake_latency(osc_q, 32'(startup_dly_i), FIXED_WAKE));
        end
      end
      ST_WAKING: begin
        if (rst_wake_i) begin
          state_d = ST_AWAKE;
          cnt_d   = '0;
        end else if (cnt_q <= CNTW'(1)) begin
          state_d = ST_AWAKE;
          pulse_d = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
      osc_q   <= 1'b0;
      t2_q    <= 1'b0;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      osc_q   <= osc_d;
      t2_q    <= t2_d;
      pulse_q <= pulse_d;
      err_q   <= err_d;
    end
  end

  assign state_o      = state_q;
  assign keep_osc_o   = osc_q;
  assign keep_t2_o    = t2_q;
  assign wake_pulse_o = pulse_q;
  assign mode_err_o   = err_q;

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse_o |=> !wake_pulse_o);
  // R10
  rst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_AWAKE && rst_wake_i) |=> (state_q == ST_AWAKE && !wake_pulse_o));
  // R2
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AWAKE && sleep_req_i && !req_mode_i.valid) |=>
      (state_q == ST_AWAKE && mode_err_o));
  // R11
  entry_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AWAKE && sleep_req_i && entry_block_i) |=> state_q == ST_AWAKE);
  // R8
  wait_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKING) |-> cnt_q != '0);

endmodule

// File: rtl/slp_clk_ctl.sv
module slp_clk_ctl (
  input  slp_pkg::slp_state_e state_i,
  input  logic                keep_osc_i,
  input  logic                keep_t2_i,
  input  logic                t2_en_i,
  input  logic                t2_async_i,
  input  logic                t2_sync_i,
  output logic                osc_en_o,
  output logic                core_clk_en_o,
  output logic                t2_async_en_o,
  output logic                t2_sync_en_o,
  output logic                sleeping_o
);
  import slp_pkg::*;

  logic t2_hold;
  assign t2_hold = keep_t2_i & t2_en_i;

  always_comb begin
    if (state_i == ST_AWAKE) begin
      osc_en_o      = 1'b1;
      core_clk_en_o = 1'b1;
      t2_async_en_o = 1'b1;
      t2_sync_en_o  = 1'b1;
      sleeping_o    = 1'b0;
    end else begin
      t2_async_en_o = t2_hold & t2_async_i;
      t2_sync_en_o  = t2_hold & t2_sync_i;
      // the synchronous feed needs the oscillator, but only timer 2 gets it
      osc_en_o      = (state_i == ST_WAKING) | keep_osc_i | (t2_hold & t2_sync_i);
      core_clk_en_o = 1'b0;
      sleeping_o    = 1'b1;
    end
  end

endmodule

// File: rtl/slpctl_top.sv
module slpctl_top #(
  parameter int DLYW       = 8,
  parameter int LVL_HOLD   = 3,
  parameter int FIXED_WAKE = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode_i,
  input  logic            sleep_req_i,
  input  logic            xtal_opt_i,
  input  logic            gie_i,
  input  logic            t2_en_i,
  input  logic            t2_async_i,
  input  logic            t2_sync_i,
  input  logic            t2_ovf_ie_i,
  input  logic            t2_cmp_ie_i,
  input  logic            t2_ovf_i,
  input  logic            t2_cmp_i,
  input  logic            rst_ext_i,
  input  logic            rst_wdt_i,
  input  logic            rst_bod_i,
  input  logic            twi_match_i,
  input  logic            ext_level_i,
  input  logic            ext_edge_i,
  input  logic            pin_chg_i,
  input  logic [DLYW-1:0] startup_dly_i,
  output logic            osc_en_o,
  output logic            core_clk_en_o,
  output logic            t2_async_en_o,
  output logic            t2_sync_en_o,
  output logic            sleeping_o,
  output logic            wake_pulse_o,
  output logic            mode_err_o
);
  import slp_pkg::*;

  slp_mode_t  req_mode;
  slp_state_e state;
  logic       keep_osc, keep_t2;
  logic       rst_wake, soft_wake, entry_block;
  logic       asleep;

  assign req_mode = decode_mode(mode_i, xtal_opt_i);
  assign asleep   = (state == ST_ASLEEP);

  slp_wake_qual #(.LVL_HOLD(LVL_HOLD)) u_qual (
    .clk(clk), .rst_n(rst_n), .asleep_i(asleep),
    .sleep_keep_t2_i(keep_t2), .req_keep_t2_i(req_mode.keep_t2),
    .gie_i(gie_i), .t2_en_i(t2_en_i),
    .t2_ovf_ie_i(t2_ovf_ie_i), .t2_cmp_ie_i(t2_cmp_ie_i),
    .t2_ovf_i(t2_ovf_i), .t2_cmp_i(t2_cmp_i),
    .twi_match_i(twi_match_i), .ext_level_i(ext_level_i),
    .ext_edge_i(ext_edge_i), .pin_chg_i(pin_chg_i),
    .rst_ext_i(rst_ext_i), .rst_wdt_i(rst_wdt_i), .rst_bod_i(rst_bod_i),
    .rst_wake_o(rst_wake), .soft_wake_o(soft_wake), .entry_block_o(entry_block)
  );

  slp_seq #(.DLYW(DLYW), .FIXED_WAKE(FIXED_WAKE)) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i),
    .req_mode_i(req_mode), .startup_dly_i(startup_dly_i),
    .rst_wake_i(rst_wake), .soft_wake_i(soft_wake), .entry_block_i(entry_block),
    .state_o(state), .keep_osc_o(keep_osc), .keep_t2_o(keep_t2),
    .wake_pulse_o(wake_pulse_o), .mode_err_o(mode_err_o)
  );

  slp_clk_ctl u_clk (
    .state_i(state), .keep_osc_i(keep_osc), .keep_t2_i(keep_t2),
    .t2_en_i(t2_en_i), .t2_async_i(t2_async_i), .t2_sync_i(t2_sync_i),
    .osc_en_o(osc_en_o), .core_clk_en_o(core_clk_en_o),
    .t2_async_en_o(t2_async_en_o), .t2_sync_en_o(t2_sync_en_o),
    .sleeping_o(sleeping_o)
  );

  // R9
  pulse_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse_o |-> (core_clk_en_o && !sleeping_o));
  // R4
  t2_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping_o && !t2_en_i) |-> (!t2_async_en_o && !t2_sync_en_o));
  // R3
  core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleeping_o) |-> !core_clk_en_o);

endmodule

// File: tb/sim_slpctl_top.sv
module sim_slpctl_top;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic sleep_req = 0, xtal = 0, gie = 0, t2en = 0, t2as = 0, t2sy = 0;
  logic ovf_ie = 0, cmp_ie = 0, ovf = 0, cmp = 0;
  logic r_ext = 0, r_wdt = 0, r_bod = 0, twi = 0, lvl = 0, edg = 0, pc = 0;
  logic [7:0] dly = 8'd1;
  logic osc_en, core_en, t2a_en, t2s_en, sleeping, wpulse, merr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slpctl_top u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .sleep_req_i(sleep_req),
    .xtal_opt_i(xtal), .gie_i(gie), .t2_en_i(t2en), .t2_async_i(t2as),
    .t2_sync_i(t2sy), .t2_ovf_ie_i(ovf_ie), .t2_cmp_ie_i(cmp_ie),
    .t2_ovf_i(ovf), .t2_cmp_i(cmp), .rst_ext_i(r_ext), .rst_wdt_i(r_wdt),
    .rst_bod_i(r_bod), .twi_match_i(twi), .ext_level_i(lvl),
    .ext_edge_i(edg), .pin_chg_i(pc), .startup_dly_i(dly),
    .osc_en_o(osc_en), .core_clk_en_o(core_en), .t2_async_en_o(t2a_en),
    .t2_sync_en_o(t2s_en), .sleeping_o(sleeping), .wake_pulse_o(wpulse),
    .mode_err_o(merr)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic request(logic [2:0] m, logic x);
    mode = m; xtal = x; sleep_req = 1; step(1); sleep_req = 0;
  endtask

  task automatic to_awake();
    r_ext = 1; step(1); r_ext = 0;
  endtask

  // steps counted from the sample where the source was raised
  task automatic wait_pulse(int limit, output int lat);
    lat = 0;
    for (int k = 1; k <= limit; k++) begin
      step(1);
      if (k == 1) begin twi = 0; edg = 0; pc = 0; ovf = 0; cmp = 0; end
      if (wpulse && lat == 0) begin lat = k; break; end
    end
  endtask

  function automatic bit valid_code(int m, int x);
    return (m == 2) || (m == 3) || ((m == 6 || m == 7) && x == 1);
  endfunction

  function automatic int exp_lat(int m, int d);
    if (m >= 6) return 6;
    return (d == 0) ? 1 : d;
  endfunction

  initial begin
    int lat;
    int codes[4] = '{2, 3, 6, 7};
    int dlys[5]  = '{0, 1, 2, 7, 13};
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk("R1 osc", osc_en, 1); chk("R1 core", core_en, 1);
    chk("R1 t2a", t2a_en, 1); chk("R1 t2s", t2s_en, 1);
    chk("R1 sleeping", sleeping, 0); chk("R1 pulse", wpulse, 0);
    chk("R1 err", merr, 0);

    // R2 decode sweep over every code and crystal option
    for (int m = 0; m < 8; m++)
      for (int x = 0; x < 2; x++) begin
        request(3'(m), 1'(x));
        chk("R2 sleeping", sleeping, int'(valid_code(m, x)));
        chk("R2 err", merr, int'(!valid_code(m, x)));
        to_awake();
        chk("R2 back awake", sleeping, 0);
      end

    // R3 R4 clock enables while asleep, all timer configurations
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 8; c++) begin
        int m = codes[i];
        bit keep;
        t2en = c[0]; t2as = c[1]; t2sy = c[2];
        keep = (m % 2 == 1) && c[0];
        request(3'(m), 1'b1);
        chk("R3 core off", core_en, 0);
        chk("R3 osc", osc_en, int'((m >= 6) || (keep && c[2])));
        chk("R4 t2 async", t2a_en, int'(keep && c[1]));
        chk("R4 t2 sync", t2s_en, int'(keep && c[2]));
        to_awake();
        chk("R3 core back", core_en, 1);
      end
    t2en = 0; t2as = 0; t2sy = 0;

    // R5 timer events as wake sources
    dly = 8'd1;
    for (int i = 0; i < 4; i++)
      for (int v = 0; v < 8; v++) begin
        int m = codes[i];
        bit exp_w;
        t2en = 1; gie = v[0];
        request(3'(m), 1'b1);
        if (v[2]) begin cmp_ie = v[1]; ovf_ie = 1'b1; cmp = 1; end
        else      begin ovf_ie = v[1]; cmp_ie = 1'b1; ovf = 1; end
        exp_w = (m % 2 == 1) && v[0] && v[1];
        wait_pulse(10, lat);
        chk("R5 timer wake", int'(lat != 0), int'(exp_w));
        if (exp_w) chk("R5 timer latency", lat, exp_lat(m, 1) + 1);
        else to_awake();
        step(1);
      end
    t2en = 0; gie = 0; ovf_ie = 0; cmp_ie = 0;

    // R6 R8 R9 latency sweep with rotating pulse sources
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 5; j++) begin
        int m = codes[i];
        dly = 8'(dlys[j]);
        request(3'(m), 1'b1);
        case (j % 3)
          0: twi = 1;
          1: edg = 1;
          default: pc = 1;
        endcase
        wait_pulse(40, lat);
        chk("R6 R8 latency", lat, exp_lat(m, dlys[j]) + 1);
        chk("R9 awake at pulse", int'(sleeping), 0);
        chk("R9 core at pulse", int'(core_en), 1);
        step(1);
        chk("R9 pulse width", wpulse, 0);
      end

    // R7 level qualification
    dly = 8'd1;
    request(3'd2, 1'b0);
    lvl = 1; step(HOLD - 1); lvl = 0;
    step(4);
    chk("R7 short run ignored", sleeping, 1);
    lvl = 1;
    wait_pulse(20, lat);
    lvl = 0;
    chk("R7 level latency", lat, HOLD + 1);
    step(1);

    // R10 reset-class abort while asleep
    request(3'd3, 1'b0);
    r_wdt = 1; step(1); r_wdt = 0;
    chk("R10 abort awake", sleeping, 0);
    chk("R10 abort no pulse", wpulse, 0);
    // R10 abort in the last cycle of the restart wait
    dly = 8'd5;
    request(3'd2, 1'b0);
    twi = 1; step(1); twi = 0;
    step(4);
    r_bod = 1; step(1); r_bod = 0;
    chk("R10 late abort awake", sleeping, 0);
    chk("R10 late abort no pulse", wpulse, 0);
    lat = 0;
    for (int k = 0; k < 10; k++) begin step(1); if (wpulse) lat = 1; end
    chk("R10 no later pulse", lat, 0);

    // R11 wake source in the same cycle as the request
    pc = 1; request(3'd2, 1'b0); pc = 0;
    chk("R11 pin change blocks", sleeping, 0);
    chk("R11 no error", merr, 0);
    lvl = 1; request(3'd6, 1'b1); lvl = 0;
    chk("R11 level blocks", sleeping, 0);
    request(3'd6, 1'b1);
    chk("R11 later request accepted", sleeping, 1);
    to_awake();

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule